// File: doc/BRIEF.md
# Impulse Slave Clock Pulse Sequencer

This block drives the two relay lines of a network of three-wire impulse slave clocks that use a top-of-hour correction scheme. A separate timekeeping counter supplies the current minute and second of the hour together with a one-cycle strobe that marks the start of each second. On each strobe the block decides the level of the plain advance line (`line_norm`) and of the hour correction line (`line_sync`) for the second that is starting, and holds both levels in registers until the next strobe.

The hour has three phases. During minutes 0 to 30 both lines pulse together at the end of every minute, which drags along clocks that have fallen far behind. During minutes 31 to 58 only the advance line pulses. In minute 59 a bounded train of catch-up pulses on the advance line brings every lagging clock up to its parked 59th-minute position. Then both lines pulse together in the closing seconds to move all clocks into the next hour. An operator request can also force the advance line high.

The controller is a small state machine whose state is the phase of the hour. `DRAG` covers minutes 0 to 30 and `PLAIN` covers minutes 31 to 58. `CATCH` covers minute 59, seconds 0 to 39. `GAP` covers minute 59, seconds 40 to 56, and `FINAL` covers minute 59, seconds 57 to 59. On every strobe the state moves to the phase decoded from the incoming time. The normal path is DRAG to PLAIN to CATCH to GAP to FINAL and back to DRAG. Any other jump is taken directly. Moving from DRAG or PLAIN into any minute-59 phase is the "enter hour end" transition, and it re-arms the catch-up counter.

Top module: `impulse_seq`

## Requirements
- R1: An active-high synchronous reset drives both lines low and clears the catch-up count and the manual pulse state.
- R2: For minutes 0 to 30, both lines are high during seconds 57, 58 and 59 and low during seconds 0 to 56.
- R3: For minutes 31 to 58, the advance line is high during seconds 57 to 59 and low otherwise. The correction line stays low for the whole minute.
- R4: In minute 59, the advance line is high on every even second from 0 to 38 and low on the odd seconds from 1 to 39. This gives 20 one-second catch-up pulses, and the correction line stays low.
- R5: In minute 59, seconds 40 to 56, both lines are low.
- R6: In minute 59, seconds 57 to 59, both lines are high together.
- R7: No more than 20 catch-up pulses are issued between entries into minute 59 from an earlier minute. If minute 59 seconds are presented again without first leaving minute 59, no further catch-up pulse appears.
- R8: While the manual request is high at a strobe, the advance line is high for that second. A rising edge of the request, sampled on strobes, keeps the advance line high for at least 3 seconds. The manual request never changes the correction line.
- R9: Both lines change only on a clock edge at which the one-second strobe is high. Changes on the time or manual inputs without a strobe have no effect on the lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe at the start of each second |
| cur_min | input | 6 | Minute of the hour, 0 to 59, valid with `sec_tick` |
| cur_sec | input | 6 | Second of the minute, 0 to 59, valid with `sec_tick` |
| man_adv | input | 1 | Manual advance request, sampled on strobes |
| line_norm | output | 1 | Plain advance relay line |
| line_sync | output | 1 | Hour correction relay line |

## Verification
The assertions assume that `cur_min` and `cur_sec` stay within 0 to 59. They also assume that `sec_tick` is a single-cycle pulse that comes with a valid time value. The time rules are checked only on cycles where the strobe is high. The bench always drives in-range values, raises the strobe for exactly one cycle with the time already set, and keeps at least one idle cycle between strobes. During the idle cycles it changes the time and manual inputs on purpose, to show that they have no effect there.

// File: rtl/isc_pkg.sv
package isc_pkg;
    typedef enum logic [2:0] {
        PH_DRAG  = 3'd0,
        PH_PLAIN = 3'd1,
        PH_CATCH = 3'd2,
        PH_GAP   = 3'd3,
        PH_FINAL = 3'd4
    } phase_e;

    localparam int SECS_PER_MIN = 60;
endpackage

// File: rtl/isc_phase_decode.sv
module isc_phase_decode
    import isc_pkg::*;
#(
    parameter int MIN_W         = 6,
    parameter int SEC_W         = 6,
    parameter int DRAG_LAST_MIN = 30,
    parameter int HOUR_LAST_MIN = 59,
    parameter int CATCH_END_SEC = 40,
    parameter int TAIL_SECS     = 3
) (
    input  logic [MIN_W-1:0] cur_min,
    input  logic [SEC_W-1:0] cur_sec,
    output phase_e           phase,
    output logic             in_tail
);
    localparam int TAIL_FIRST = SECS_PER_MIN - TAIL_SECS;

    always_comb begin
        in_tail = (int'(cur_sec) >= TAIL_FIRST);
        if (int'(cur_min) == HOUR_LAST_MIN) begin
            if (in_tail)
                phase = PH_FINAL;
            else if (int'(cur_sec) < CATCH_END_SEC)
                phase = PH_CATCH;
            else
                phase = PH_GAP;
        end else if (int'(cur_min) <= DRAG_LAST_MIN) begin
            phase = PH_DRAG;
        end else begin
            phase = PH_PLAIN;
        end
    end
endmodule

// File: rtl/isc_catchup_ctr.sv
module isc_catchup_ctr #(
    parameter int CATCH_PULSES = 20,
    localparam int CNT_W       = $clog2(CATCH_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rearm,
    input  logic             want,
    output logic             fire,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        base = rearm ? '0 : cnt_q;
        fire = want && (int'(base) < CATCH_PULSES);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= base + CNT_W'(fire);
    end

    assign count = cnt_q;
endmodule

// File: rtl/isc_manual_stretch.sv
module isc_manual_stretch #(
    parameter int PULSE_SECS = 3,
    localparam int STR_W     = $clog2(PULSE_SECS)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    output logic hold
);
    logic             req_q;
    logic [STR_W-1:0] left_q;
    logic             edge_seen;

    assign edge_seen = req && !req_q;
    assign hold      = req || (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            left_q <= '0;
        end else if (tick) begin
            req_q <= req;
            if (edge_seen)
                left_q <= STR_W'(PULSE_SECS - 1);
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/impulse_seq.sv
module impulse_seq
    import isc_pkg::*;
#(
    parameter int MIN_W         = 6,
    parameter int SEC_W         = 6,
    parameter int DRAG_LAST_MIN = 30,
    parameter int HOUR_LAST_MIN = 59,
    parameter int CATCH_END_SEC = 40,
    parameter int CATCH_PULSES  = 20,
    parameter int TAIL_SECS     = 3,
    parameter int MAN_SECS      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_tick,
    input  logic [MIN_W-1:0] cur_min,
    input  logic [SEC_W-1:0] cur_sec,
    input  logic             man_adv,
    output logic             line_norm,
    output logic             line_sync
);
    localparam int CNT_W = $clog2(CATCH_PULSES + 1);

    phase_e           state_q;
    phase_e           phase_nxt;
    logic             in_tail;
    logic             rearm;
    logic             want;
    logic             fire;
    logic [CNT_W-1:0] catch_cnt;
    logic             man_hold;
    logic             norm_d;
    logic             sync_d;

    isc_phase_decode #(
        .MIN_W(MIN_W), .SEC_W(SEC_W), .DRAG_LAST_MIN(DRAG_LAST_MIN),
        .HOUR_LAST_MIN(HOUR_LAST_MIN), .CATCH_END_SEC(CATCH_END_SEC),
        .TAIL_SECS(TAIL_SECS)
    ) u_dec (
        .cur_min(cur_min), .cur_sec(cur_sec),
        .phase(phase_nxt), .in_tail(in_tail)
    );

    // re-arm on entering the hour end from an earlier phase
    assign rearm = (state_q == PH_DRAG || state_q == PH_PLAIN) &&
                   (phase_nxt == PH_CATCH || phase_nxt == PH_GAP ||
                    phase_nxt == PH_FINAL);
    assign want  = (phase_nxt == PH_CATCH) && !cur_sec[0];

    isc_catchup_ctr #(.CATCH_PULSES(CATCH_PULSES)) u_ctr (
        .clk(clk), .rst(rst), .tick(sec_tick), .rearm(rearm),
        .want(want), .fire(fire), .count(catch_cnt)
    );

    isc_manual_stretch #(.PULSE_SECS(MAN_SECS)) u_man (
        .clk(clk), .rst(rst), .tick(sec_tick), .req(man_adv),
        .hold(man_hold)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PH_DRAG;
        else if (sec_tick)
            state_q <= phase_nxt;
    end

    // output decode
    always_comb begin
        unique case (phase_nxt)
            PH_DRAG:  begin norm_d = in_tail; sync_d = in_tail; end
            PH_PLAIN: begin norm_d = in_tail; sync_d = 1'b0;    end
            PH_CATCH: begin norm_d = fire;    sync_d = 1'b0;    end
            PH_GAP:   begin norm_d = 1'b0;    sync_d = 1'b0;    end
            PH_FINAL: begin norm_d = 1'b1;    sync_d = 1'b1;    end
            default:  begin norm_d = 1'b0;    sync_d = 1'b0;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_norm <= 1'b0;
            line_sync <= 1'b0;
        end else if (sec_tick) begin
            line_norm <= norm_d || man_hold;
            line_sync <= sync_d;
        end
    end
endmodule

// File: rtl/impulse_seq_checker.sv
module impulse_seq_checker #(
    parameter int MIN_W         = 6,
    parameter int SEC_W         = 6,
    parameter int DRAG_LAST_MIN = 30,
    parameter int HOUR_LAST_MIN = 59,
    parameter int CATCH_END_SEC = 40,
    parameter int CATCH_PULSES  = 20,
    parameter int TAIL_SECS     = 3,
    parameter int CNT_W         = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_tick,
    input logic [MIN_W-1:0] cur_min,
    input logic [SEC_W-1:0] cur_sec,
    input logic             line_norm,
    input logic             line_sync,
    input logic [CNT_W-1:0] catch_cnt
);
    localparam int TAIL_FIRST = 60 - TAIL_SECS;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!line_norm && !line_sync));

    assert_sync_has_norm_R2: assert property (@(posedge clk) disable iff (rst)
        line_sync |-> line_norm);

    assert_plain_no_sync_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && int'(cur_min) > DRAG_LAST_MIN && int'(cur_min) < HOUR_LAST_MIN)
        |=> !line_sync);

    assert_gap_no_sync_R5: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && int'(cur_min) == HOUR_LAST_MIN &&
         int'(cur_sec) >= CATCH_END_SEC && int'(cur_sec) < TAIL_FIRST)
        |=> !line_sync);

    assert_final_both_R6: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && int'(cur_min) == HOUR_LAST_MIN && int'(cur_sec) >= TAIL_FIRST)
        |=> (line_norm && line_sync));

    assert_catch_cap_R7: assert property (@(posedge clk) disable iff (rst)
        int'(catch_cnt) <= CATCH_PULSES);

    assert_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> ($stable(line_norm) && $stable(line_sync)));
endmodule

bind impulse_seq impulse_seq_checker #(
    .MIN_W(MIN_W), .SEC_W(SEC_W), .DRAG_LAST_MIN(DRAG_LAST_MIN),
    .HOUR_LAST_MIN(HOUR_LAST_MIN), .CATCH_END_SEC(CATCH_END_SEC),
    .CATCH_PULSES(CATCH_PULSES), .TAIL_SECS(TAIL_SECS),
    .CNT_W($clog2(CATCH_PULSES + 1))
) u_chk (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .cur_min(cur_min),
    .cur_sec(cur_sec), .line_norm(line_norm), .line_sync(line_sync),
    .catch_cnt(catch_cnt)
);

// File: tb/impulse_seq_bench.sv
module impulse_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [5:0] cur_min = '0;
    logic [5:0] cur_sec = '0;
    logic       man_adv = 1'b0;
    logic       line_norm;
    logic       line_sync;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic  norm;
        logic  sync;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // bench-side model state
    int  m_cnt = 0;
    int  m_left = 0;
    bit  m_prev59 = 0;
    bit  m_manprev = 0;
    int  obs_catch = 0;

    impulse_seq u_impulse_seq (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .cur_min(cur_min),
        .cur_sec(cur_sec), .man_adv(man_adv),
        .line_norm(line_norm), .line_sync(line_sync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic an, input logic as_, input logic en,
                         input logic es, input string tag);
        n_checks++;
        if (an !== en || as_ !== es) begin
            n_fail++;
            $display("FAIL %s: norm/sync actual %b%b expected %b%b", tag, an, as_, en, es);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_left = 0; m_prev59 = 0; m_manprev = 0;
    endtask

    // driver: one strobed second with expected outcome pushed to scoreboard
    task automatic step(input int mi, input int se, input bit man, input string tag);
        exp_t e;
        bit   in59, tail, n, s;
        in59 = (mi == 59);
        tail = (se >= 57);
        if (in59 && !m_prev59) m_cnt = 0;
        n = 0; s = 0;
        if (!in59) begin
            n = tail;
            s = (mi <= 30) ? tail : 1'b0;
        end else if (tail) begin
            n = 1; s = 1;
        end else if (se < 40 && (se % 2) == 0 && m_cnt < 20) begin
            n = 1; m_cnt++;
        end
        n = n | man | (m_left != 0);
        if (man && !m_manprev) m_left = 2;
        else if (m_left != 0) m_left--;
        m_manprev = man;
        m_prev59 = in59;
        e.norm = n; e.sync = s; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cur_min = 6'(mi); cur_sec = 6'(se); man_adv = man; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    // monitor
    logic pend = 1'b0;
    always @(posedge clk) pend <= sec_tick;
    always @(negedge clk) begin
        if (pend) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: result with no expected item");
            end else begin
                e = exp_q.pop_front();
                if (e.tag == "R4" && line_norm) obs_catch++;
                check(line_norm, line_sync, e.norm, e.sync, e.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(line_norm, line_sync, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        model_reset();

        // R2 dual drag pulses
        for (int s = 54; s < 60; s++) step(5, s, 0, "R2");
        step(30, 0, 0, "R2");
        step(30, 57, 0, "R2");
        step(0, 59, 0, "R2");
        // R3 normal only
        for (int s = 55; s < 60; s++) step(31, s, 0, "R3");
        step(58, 57, 0, "R3");
        step(58, 10, 0, "R3");

        // minute 59 full sweep
        obs_catch = 0;
        for (int s = 0; s < 40; s++) step(59, s, 0, "R4");
        for (int s = 40; s < 57; s++) step(59, s, 0, "R5");
        for (int s = 57; s < 60; s++) step(59, s, 0, "R6");
        @(negedge clk); @(negedge clk);
        check(logic'(obs_catch == 20), 1'b0, 1'b1, 1'b0, "R4 pulse count");

        // R7 cap: re-present minute 59 without leaving
        for (int s = 0; s < 12; s++) step(59, s, 0, "R7");
        // leaving and re-entering re-arms
        step(10, 0, 0, "R7");
        step(59, 0, 0, "R7");
        step(59, 2, 0, "R7");

        // R8 manual: single-second request stretched to 3 s
        step(40, 10, 1, "R8");
        step(40, 11, 0, "R8");
        step(40, 12, 0, "R8");
        step(40, 13, 0, "R8");
        // held request
        for (int s = 20; s < 25; s++) step(40, s, 1, "R8");
        step(40, 25, 0, "R8");
        step(40, 26, 0, "R8");
        step(40, 27, 0, "R8");
        // manual in drag minute leaves sync low mid-minute
        step(3, 5, 1, "R8");
        step(3, 6, 0, "R8");
        step(3, 7, 0, "R8");
        step(3, 8, 0, "R8");

        // R9: inputs change with no strobe
        step(20, 57, 0, "R9");
        @(negedge clk);
        cur_min = 6'd40; cur_sec = 6'd5; man_adv = 1'b1;
        repeat (4) @(negedge clk);
        check(line_norm, line_sync, 1'b1, 1'b1, "R9");
        man_adv = 1'b0;
        step(20, 10, 0, "R9");

        // R1 reset in the middle of a pulse
        step(59, 58, 0, "R1");
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check(line_norm, line_sync, 1'b0, 1'b0, "R1");
        rst = 1'b0;
        model_reset();
        step(59, 4, 0, "R1");
        step(59, 5, 0, "R1");

        @(negedge clk); @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: %0d expected items left", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule